// File: doc/BRIEF.md
# Top-N Object Selector

The selector takes a stream of 32-bit trigger object words that belong to one event. Each word arrives with a valid strobe, an end-of-event flag and a two-bit object kind. While the event arrives, the block keeps only the highest-energy words in a register array sorted by energy. It inserts at most one word per cycle. Both the number of words kept and the bit field that holds the energy depend on the kind of object.

When the end-of-event word has been accepted, the block sends a burst of exactly N words, highest energy first. Slots that no object filled are sent as zero words. Input is held off with a ready signal while the burst is in progress. After the burst the array is empty and the next event can start.

Top module: `topn_selector`

## Requirements
- R1: For kind code 0 (small jet), and for the spare code 3, which is handled the same way, the burst has 7 words. They are the 7 stored words with the largest value in bits 22:12, sent in descending order of that field.
- R2: For kind code 1 (large jet), the burst is a single word. It is the stored word with the largest value in bits 22:10.
- R3: For kind code 2 (tau), the burst has 6 words. They are the largest words by bits 22:12, sent in descending order.
- R4: An input word equal to zero completes its handshake but is never stored.
- R5: When fewer than N nonzero words arrived, the burst is completed with zero words after the stored ones. The burst always has exactly N words.
- R6: When two words have equal energy fields, the word accepted earlier is sent first.
- R7: The burst starts in the cycle after the end-of-event word is accepted. It sends one word per cycle with out_valid high and no gaps, and out_last is high only on the N-th word.
- R8: in_ready is low exactly while out_valid is high. A word presented during that time is not accepted and does not appear in any burst.
- R9: The kind is taken from the first accepted word of an event. The in_type of later words in the same event has no effect.
- R10: No word from an earlier event appears in the burst of a later event.
- R11: During and after a synchronous reset, out_valid and out_last are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Selector can accept a word |
| in_word | input | 32 | Object word |
| in_type | input | 2 | Object kind: 0 small jet, 1 large jet, 2 tau, 3 spare (handled as small jet) |
| in_last | input | 1 | Word is the last of its event |
| out_valid | output | 1 | Burst word is valid |
| out_word | output | 32 | Selected object word or zero padding |
| out_last | output | 1 | N-th and final word of the burst |

## Verification
Two actions can fall on the same clock edge. The end-of-event word is inserted into the array, and the head of the freshly updated array is loaded into the output register. The bench provokes this by making the final word of an event the largest, the smallest, a tie, or zero. The reference model then expects that word at its sorted place in the first output cycle. The end of one burst also coincides with clearing the array while the next event's first word is already held on the input. The behavioural model checks every cycle that this word waits, is accepted once, and that nothing stale comes back.

// File: rtl/topn_pkg.sv
package topn_pkg;

  typedef enum logic [1:0] {
    OBJ_SMALL_JET = 2'd0,
    OBJ_LARGE_JET = 2'd1,
    OBJ_TAU       = 2'd2,
    OBJ_SPARE     = 2'd3
  } obj_kind_e;

endpackage

// File: rtl/topn_key_sel.sv
// Per-kind sort key extraction and retention depth.
module topn_key_sel
  import topn_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int KEY_MSB   = 22,
  parameter int SMALL_LSB = 12,
  parameter int LARGE_LSB = 10,
  parameter int TAU_LSB   = 12,
  parameter int KEY_W     = 13,
  parameter int SMALL_N   = 7,
  parameter int LARGE_N   = 1,
  parameter int TAU_N     = 6,
  parameter int CNT_W     = 3
) (
  input  obj_kind_e          kind,
  input  logic [WORD_W-1:0]  word,
  output logic [KEY_W-1:0]   key,
  output logic [CNT_W-1:0]   depth
);

  localparam int SMALL_BITS = KEY_MSB - SMALL_LSB + 1;
  localparam int LARGE_BITS = KEY_MSB - LARGE_LSB + 1;
  localparam int TAU_BITS   = KEY_MSB - TAU_LSB + 1;
  localparam logic [WORD_W-1:0] SMALL_MASK = (WORD_W'(1) << SMALL_BITS) - WORD_W'(1);
  localparam logic [WORD_W-1:0] LARGE_MASK = (WORD_W'(1) << LARGE_BITS) - WORD_W'(1);
  localparam logic [WORD_W-1:0] TAU_MASK   = (WORD_W'(1) << TAU_BITS) - WORD_W'(1);

  always_comb begin
    case (kind)
      OBJ_LARGE_JET: begin
        key   = KEY_W'((word >> LARGE_LSB) & LARGE_MASK);
        depth = CNT_W'(LARGE_N);
      end
      OBJ_TAU: begin
        key   = KEY_W'((word >> TAU_LSB) & TAU_MASK);
        depth = CNT_W'(TAU_N);
      end
      default: begin  // small jet and spare code (R1)
        key   = KEY_W'((word >> SMALL_LSB) & SMALL_MASK);
        depth = CNT_W'(SMALL_N);
      end
    endcase
  end

endmodule

// File: rtl/topn_slot_array.sv
// Sorted register array: one insertion, one shift or one clear per cycle.
module topn_slot_array #(
  parameter int WORD_W = 32,
  parameter int KEY_W  = 13,
  parameter int DEPTH  = 7,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_en,
  input  logic [KEY_W-1:0]  ins_key,
  input  logic [WORD_W-1:0] ins_word,
  input  logic [CNT_W-1:0]  limit,
  input  logic              shift_en,
  input  logic              clear,
  output logic [WORD_W-1:0] head_nxt
);

  logic [DEPTH-1:0][WORD_W-1:0] word_q, word_n, up_word, dn_word;
  logic [DEPTH-1:0][KEY_W-1:0]  key_q, key_n, up_key, dn_key;
  logic [DEPTH-1:0]             occ_q, occ_n, up_occ, dn_occ;
  logic [DEPTH-1:0]             beats, beat_prev, in_range;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      // strict compare keeps earlier arrivals ahead on ties (R6)
      assign beats[i]    = !occ_q[i] || (ins_key > key_q[i]);
      assign in_range[i] = (CNT_W'(i) < limit);
      if (i == 0) begin : g_head
        assign beat_prev[i] = 1'b0;
        assign up_word[i]   = '0;
        assign up_key[i]    = '0;
        assign up_occ[i]    = 1'b0;
      end else begin : g_body
        assign beat_prev[i] = beats[i-1];
        assign up_word[i]   = word_q[i-1];
        assign up_key[i]    = key_q[i-1];
        assign up_occ[i]    = occ_q[i-1];
      end
      if (i == DEPTH - 1) begin : g_tail
        assign dn_word[i] = '0;
        assign dn_key[i]  = '0;
        assign dn_occ[i]  = 1'b0;
      end else begin : g_inner
        assign dn_word[i] = word_q[i+1];
        assign dn_key[i]  = key_q[i+1];
        assign dn_occ[i]  = occ_q[i+1];
      end
    end
  endgenerate

  always_comb begin
    word_n = word_q;
    key_n  = key_q;
    occ_n  = occ_q;
    if (clear) begin
      occ_n = '0;
    end else if (shift_en) begin
      word_n = dn_word;
      key_n  = dn_key;
      occ_n  = dn_occ;
    end else if (ins_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (beats[i]) begin
          if (beat_prev[i]) begin
            word_n[i] = up_word[i];
            key_n[i]  = up_key[i];
            occ_n[i]  = up_occ[i] && in_range[i];
          end else begin
            word_n[i] = ins_word;
            key_n[i]  = ins_key;
            occ_n[i]  = in_range[i];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      key_q  <= '0;
      occ_q  <= '0;
    end else begin
      word_q <= word_n;
      key_q  <= key_n;
      occ_q  <= occ_n;
    end
  end

  assign head_nxt = occ_n[0] ? word_n[0] : '0;

endmodule

// File: rtl/topn_ctrl.sv
// Event handshake, kind latch, burst sequencing and registered outputs.
module topn_ctrl
  import topn_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [WORD_W-1:0] in_word,
  input  obj_kind_e         in_kind,
  output obj_kind_e         kind_eff,
  input  logic [CNT_W-1:0]  depth_eff,
  output logic              in_ready,
  output logic              ins_en,
  output logic              shift_en,
  output logic              clear,
  input  logic [WORD_W-1:0] head_nxt,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last
);

  logic             burst_q;
  logic             first_q;
  obj_kind_e        kind_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] n_q;
  logic             accept;
  logic             done;

  assign kind_eff = first_q ? in_kind : kind_q;   // R9
  assign in_ready = !burst_q;                      // R8
  assign accept   = in_valid && in_ready;
  assign ins_en   = accept && (in_word != '0);     // R4
  assign shift_en = burst_q;
  assign done     = burst_q && (cnt_q == n_q - CNT_W'(1));
  assign clear    = done;                          // R10

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_q   <= 1'b0;
      first_q   <= 1'b1;
      kind_q    <= OBJ_SMALL_JET;
      cnt_q     <= '0;
      n_q       <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_last  <= 1'b0;
    end else begin
      if (accept) begin
        first_q <= in_last;
        if (first_q) kind_q <= in_kind;
        if (in_last) begin
          burst_q   <= 1'b1;
          cnt_q     <= '0;
          n_q       <= depth_eff;
          out_valid <= 1'b1;
          out_word  <= head_nxt;
          out_last  <= (depth_eff == CNT_W'(1));
        end
      end
      if (burst_q) begin
        if (done) begin
          burst_q   <= 1'b0;
          out_valid <= 1'b0;
          out_word  <= '0;
          out_last  <= 1'b0;
        end else begin
          cnt_q    <= cnt_q + CNT_W'(1);
          out_word <= head_nxt;
          out_last <= (cnt_q + CNT_W'(1) == n_q - CNT_W'(1));
        end
      end
    end
  end

endmodule

// File: rtl/topn_selector.sv
module topn_selector
  import topn_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int KEY_MSB   = 22,
  parameter int SMALL_LSB = 12,
  parameter int LARGE_LSB = 10,
  parameter int TAU_LSB   = 12,
  parameter int SMALL_N   = 7,
  parameter int LARGE_N   = 1,
  parameter int TAU_N     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [1:0]        in_type,
  input  logic              in_last,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last
);

  localparam int MIN_LSB_A = (SMALL_LSB < LARGE_LSB) ? SMALL_LSB : LARGE_LSB;
  localparam int MIN_LSB   = (MIN_LSB_A < TAU_LSB) ? MIN_LSB_A : TAU_LSB;
  localparam int MAX_LSB_A = (SMALL_LSB > LARGE_LSB) ? SMALL_LSB : LARGE_LSB;
  localparam int MAX_LSB   = (MAX_LSB_A > TAU_LSB) ? MAX_LSB_A : TAU_LSB;
  localparam int KEY_W     = KEY_MSB - MIN_LSB + 1;
  localparam int MAX_N_A   = (SMALL_N > LARGE_N) ? SMALL_N : LARGE_N;
  localparam int MAX_N     = (MAX_N_A > TAU_N) ? MAX_N_A : TAU_N;
  localparam int CNT_W     = $clog2(MAX_N + 1);

  obj_kind_e         kind_eff;
  logic [KEY_W-1:0]  ins_key;
  logic [CNT_W-1:0]  depth_eff;
  logic              ins_en, shift_en, clear;
  logic [WORD_W-1:0] head_nxt;

  topn_key_sel #(
    .WORD_W(WORD_W), .KEY_MSB(KEY_MSB), .SMALL_LSB(SMALL_LSB),
    .LARGE_LSB(LARGE_LSB), .TAU_LSB(TAU_LSB), .KEY_W(KEY_W),
    .SMALL_N(SMALL_N), .LARGE_N(LARGE_N), .TAU_N(TAU_N), .CNT_W(CNT_W)
  ) u_key (
    .kind (kind_eff),
    .word (in_word),
    .key  (ins_key),
    .depth(depth_eff)
  );

  topn_ctrl #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_word  (in_word),
    .in_kind  (obj_kind_e'(in_type)),
    .kind_eff (kind_eff),
    .depth_eff(depth_eff),
    .in_ready (in_ready),
    .ins_en   (ins_en),
    .shift_en (shift_en),
    .clear    (clear),
    .head_nxt (head_nxt),
    .out_valid(out_valid),
    .out_word (out_word),
    .out_last (out_last)
  );

  topn_slot_array #(
    .WORD_W(WORD_W), .KEY_W(KEY_W), .DEPTH(MAX_N), .CNT_W(CNT_W)
  ) u_slots (
    .clk     (clk),
    .rst     (rst),
    .ins_en  (ins_en),
    .ins_key (ins_key),
    .ins_word(in_word),
    .limit   (depth_eff),
    .shift_en(shift_en),
    .clear   (clear),
    .head_nxt(head_nxt)
  );

endmodule

// File: rtl/topn_selector_chk.sv
module topn_selector_chk #(
  parameter int WORD_W  = 32,
  parameter int KEY_MSB = 22,
  parameter int TOP_LSB = 12,
  parameter int MAX_N   = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_last,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_word,
  input logic              out_last
);

  logic [7:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) len_q <= '0;
    else if (out_valid && out_last) len_q <= '0;
    else if (out_valid) len_q <= len_q + 8'd1;
  end

  a_r11_reset_idle: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_last && in_ready));

  a_r8_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  a_r7_start: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> out_valid);

  a_r7_unbroken: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> out_valid);

  a_r7_end: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |=> !out_valid);

  a_r1_max_len: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(len_q) < MAX_N));

  a_r1_descending: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid) && !$past(out_last))
      |-> (out_word[KEY_MSB:TOP_LSB] <= $past(out_word[KEY_MSB:TOP_LSB])));

  a_r5_pad_tail: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid) && !$past(out_last) && ($past(out_word) == '0))
      |-> (out_word == '0));

endmodule

bind topn_selector topn_selector_chk #(
  .WORD_W(WORD_W), .KEY_MSB(KEY_MSB), .TOP_LSB(MAX_LSB), .MAX_N(MAX_N)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_last  (in_last),
  .out_valid(out_valid),
  .out_word (out_word),
  .out_last (out_last)
);

// File: tb/topn_selector_tb.sv
`timescale 1ns/1ps
module topn_selector_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [1:0]  in_type = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_last;

  int checks = 0;
  int errors = 0;
  string cur_req = "R11";

  int unsigned ev_list[$];
  int unsigned exp_out[$];
  bit ev_started = 0;
  int ev_kind = 0;

  always #2.5 clk = ~clk;

  topn_selector u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_type(in_type), .in_last(in_last),
    .out_valid(out_valid), .out_word(out_word), .out_last(out_last)
  );

  function automatic int unsigned keyof(int kind, int unsigned w);
    if (kind == 1) return (w >> 10) & 32'h1fff;
    return (w >> 12) & 32'h7ff;
  endfunction

  function automatic int depthof(int kind);
    if (kind == 1) return 1;
    if (kind == 2) return 6;
    return 7;
  endfunction

  function automatic int unsigned mk(int kind, int unsigned key, int unsigned salt);
    if (kind == 1) return (key << 10) | (salt & 32'h3ff) | ((salt & 32'h1ff) << 23);
    return (key << 12) | (salt & 32'hfff) | ((salt & 32'h1ff) << 23);
  endfunction

  function automatic void model_accept(int unsigned w, int t, bit l);
    int p;
    if (!ev_started) begin
      ev_kind = t;
      ev_started = 1;
    end
    if (w != 0) begin
      p = ev_list.size();
      for (int i = 0; i < ev_list.size(); i++) begin
        if (keyof(ev_kind, w) > keyof(ev_kind, ev_list[i])) begin
          p = i;
          break;
        end
      end
      ev_list.insert(p, w);
    end
    if (l) begin
      for (int k = 0; k < depthof(ev_kind); k++)
        exp_out.push_back(k < ev_list.size() ? ev_list[k] : 0);
      ev_list.delete();
      ev_started = 0;
    end
  endfunction

  task automatic check_outputs();
    bit ev;
    int unsigned ew;
    bit el;
    bit er;
    ev = (exp_out.size() > 0);
    ew = ev ? exp_out[0] : 0;
    el = ev && (exp_out.size() == 1);
    er = !ev;
    checks++;
    if (out_valid !== ev || in_ready !== er || out_last !== el ||
        (ev && out_word !== ew)) begin
      errors++;
      $display("FAIL %s: valid=%0b word=%h last=%0b ready=%0b expected valid=%0b word=%h last=%0b ready=%0b",
               cur_req, out_valid, out_word, out_last, in_ready, ev, ew, el, er);
    end
  endtask

  task automatic cyc(bit v, int unsigned w, int t, bit l);
    check_outputs();
    in_valid = v;
    in_word  = w;
    in_type  = t[1:0];
    in_last  = l;
    if (exp_out.size() > 0) void'(exp_out.pop_front());
    else if (v) model_accept(w, t, l);
    @(negedge clk);
  endtask

  // present a word until it is accepted (stalls behind a burst: R8)
  task automatic put(int unsigned w, int t, bit l);
    bit acc = 0;
    while (!acc) begin
      acc = (exp_out.size() == 0);
      cyc(1, w, t, l);
    end
  endtask

  task automatic flush();
    while (exp_out.size() > 0) cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cur_req = "R11";
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);

    // R1: ten small jets, final word is the largest
    cur_req = "R1";
    put(mk(0, 12, 1), 0, 0); put(mk(0, 300, 2), 0, 0); put(mk(0, 5, 3), 0, 0);
    put(mk(0, 77, 4), 0, 0); put(mk(0, 1, 5), 0, 0);   put(mk(0, 900, 6), 0, 0);
    put(mk(0, 40, 7), 0, 0); put(mk(0, 2, 8), 0, 0);   put(mk(0, 500, 9), 0, 0);
    put(mk(0, 2047, 10), 0, 1);
    flush();

    // R1: spare code 3 behaves as small jet
    put(mk(0, 9, 11), 3, 0); put(mk(0, 30, 12), 3, 1);
    flush();

    // R3: tau keeps six
    cur_req = "R3";
    for (int i = 0; i < 8; i++) put(mk(2, (i * 37) % 23 + 1, i + 20), 2, i == 7);
    flush();

    // R2: large jet, keys differ only in bits 11:10
    cur_req = "R2";
    put(32'h0000_1800, 1, 0); put(32'h0000_1c00, 1, 0); put(32'h0000_1400, 1, 1);
    flush();

    // R4 / R5: zero words dropped, padding follows
    cur_req = "R4";
    put(mk(0, 3, 1), 0, 0); put(0, 0, 0); put(mk(0, 8, 2), 0, 0); put(0, 0, 0);
    put(mk(0, 6, 3), 0, 1);
    flush();
    cur_req = "R5";
    put(0, 2, 1);
    flush();

    // R6: ties keep arrival order, last word ties the first
    cur_req = "R6";
    put(mk(2, 50, 1), 2, 0); put(mk(2, 50, 2), 2, 0); put(mk(2, 60, 3), 2, 0);
    put(mk(2, 50, 4), 2, 1);
    flush();

    // R9: kind from first word; later in_type ignored
    cur_req = "R9";
    put(32'h0000_1800, 1, 0); put(32'h0000_1c00, 0, 1);
    flush();

    // R8 / R10: back-to-back events, next words stall behind each burst
    cur_req = "R8";
    put(mk(0, 100, 1), 0, 0); put(mk(0, 200, 2), 0, 1);
    put(mk(0, 7, 3), 0, 1);
    cur_req = "R10";
    put(mk(1, 9, 4), 1, 1);
    put(0, 2, 1);
    flush();

    // R7: randomized events with gaps, ties and zeros
    cur_req = "R7";
    for (int e = 0; e < 60; e++) begin
      int t = $urandom % 4;
      int n = 1 + $urandom % 10;
      for (int i = 0; i < n; i++) begin
        int unsigned w = ($urandom % 5 == 0) ? 0 : mk(t, $urandom % 8, $urandom);
        if ($urandom % 3 == 0) cyc(0, 0, 0, 0);
        put(w, ($urandom % 4 == 0) ? $urandom % 4 : t, i == n - 1);
      end
      if ($urandom % 2 == 0) flush();
    end
    flush();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule